// File: doc/BRIEF.md
# Transmit UTOPIA Multi-PHY Address Matcher

This block is the transmit-side slave logic for a multi-channel ATM device. The device shares one UTOPIA Level 2 Multi-PHY bus with a single ATM Layer master. Each channel is known on that bus by a 5-bit address. A host assigns these addresses through two 8-bit registers that act as an indirect pair. A channel-pointer register names the channel. A channel-address register then holds the bus address of the channel that the pointer names, for both writes and reads.

On the bus side, the block serves two operations from the master. In a poll, the master puts an address on the bus while the active-low enable is deasserted. In the next cycle the block drives the cell-available flag with the space input of the channel that owns that address. In a selection, the same address phase latches that channel as the target of the following cell write. Later cycles with the enable asserted pass the start-of-cell and write strobes to that one channel only. The block also counts the beats of each 53-byte cell, so that a host write never moves a channel's address in the middle of a cell.

Top module: `utx_mphy_addr_match`

## Requirements
- R1: A host write to offset 0x597 stores data bits 4:0 as the channel pointer. Reading offset 0x597 returns the pointer in bits 4:0, with bits 7:5 reading 0. A read of any other offset that is not 0x593 returns 0.
- R2: A host write to offset 0x593 sets the bus address of the channel that the pointer names (channel n means pointer value n). Reading offset 0x593 returns that channel's address in effect, with bits 7:5 reading 0. When the pointer is NCH or above, writes to 0x593 are ignored and reads return 0.
- R3: After reset, no channel holds a valid address and no channel is selected. clav_oe is low, the pointer reads 0, and every address reads 0. Once a channel has been given an address, it stays valid.
- R4: When txenb_n is high at a clock edge and txaddr equals the valid address of a channel, clav_oe is 1 in the following cycle. In that cycle clav equals that channel's ch_space bit as sampled at that edge.
- R5: When txenb_n is low at an edge, or txaddr matches no valid channel, clav_oe and clav are 0 in the following cycle.
- R6: Address 5'h1F never matches any channel, even a channel that has been programmed with 5'h1F.
- R7: At an edge with txenb_n high, a matching address selects that channel. A non-matching address other than 5'h1F clears the selection. 5'h1F leaves the selection unchanged. The selection never changes while txenb_n is low.
- R8: While txenb_n is low, ch_wr is one-hot on the selected channel and ch_soc equals ch_wr gated by txsoc. Both are all-zero when txenb_n is high or when no channel is selected.
- R9: A beat with txsoc high starts a cell, and the cell ends with its 53rd beat. A beat is an edge where txenb_n is low and a channel is selected. An address write made during a cell is held back and takes effect at the first edge after the cell ends. Until then, readback returns the old value. The last write held back for a channel wins.
- R10: When several channels share one address, the channel with the lowest index answers the poll and is the one selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the host side and the bus side |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | HAW (12) | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| txenb_n | input | 1 | Bus enable, active low; high marks an address phase |
| txaddr | input | 5 | Bus address from the master |
| txsoc | input | 1 | Start-of-cell from the master |
| ch_space | input | NCH (3) | Per-channel cell-space-available flags |
| clav | output | 1 | Cell-available response to a poll |
| clav_oe | output | 1 | Drive enable for clav; low models the tri-state condition |
| ch_soc | output | NCH (3) | Start-of-cell strobe routed to the selected channel |
| ch_wr | output | NCH (3) | Write strobe routed to the selected channel |

## Verification
The polls use distinct addresses, a shared address, the null address and an unowned address. This shows the difference between a real match, a priority pick, the null rule and the no-answer case. Each poll is run against a different mix of space flags, so clav reveals which channel answered. Selection is tested with three kinds of follow-up address phase: a matching one, a foreign one and a null one. The strobes under the enable then show whether the selection moved, was cleared or was kept. One full 53-beat cell carries an address write in its middle. This separates an immediate commit from a deferred one, and it also checks where the cell boundary falls.

// File: rtl/utx_pkg.sv
package utx_pkg;
    localparam int UTX_AW = 5;
    localparam logic [UTX_AW-1:0] UTX_NULL_ADDR = 5'h1F;
    typedef logic [UTX_AW-1:0] utx_addr_t;
endpackage

// File: rtl/utx_addr_regs.sv
module utx_addr_regs
    import utx_pkg::*;
#(
    parameter int NCH = 3,
    parameter int HAW = 12,
    parameter logic [HAW-1:0] PTR_OFS = 12'h597,
    parameter logic [HAW-1:0] ADR_OFS = 12'h593
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [HAW-1:0]           host_addr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    input  logic                     cell_active,
    output logic [NCH-1:0][UTX_AW-1:0] tbl_addr,
    output logic [NCH-1:0]           tbl_valid
);
    typedef struct packed {
        utx_addr_t                   ptr;
        logic [NCH-1:0][UTX_AW-1:0]  addr;
        logic [NCH-1:0]              valid;
        logic [NCH-1:0]              pend;
        logic [NCH-1:0][UTX_AW-1:0]  pend_addr;
    } regs_t;

    regs_t r_d, r_q;
    logic wr_ptr, wr_adr;
    logic [NCH-1:0] wr_hit;
    logic unused_wbits;

    assign unused_wbits = ^host_wdata[7:UTX_AW];
    assign wr_ptr = host_wr && (host_addr == PTR_OFS);
    assign wr_adr = host_wr && (host_addr == ADR_OFS);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            wr_hit[i] = wr_adr && (r_q.ptr == UTX_AW'(i));
        end
    end

    always_comb begin
        r_d = r_q;
        if (wr_ptr) r_d.ptr = host_wdata[UTX_AW-1:0];
        for (int i = 0; i < NCH; i++) begin
            if (!cell_active) begin
                if (wr_hit[i]) begin
                    r_d.addr[i]  = host_wdata[UTX_AW-1:0];
                    r_d.valid[i] = 1'b1;
                    r_d.pend[i]  = 1'b0;
                end else if (r_q.pend[i]) begin
                    r_d.addr[i]  = r_q.pend_addr[i];
                    r_d.valid[i] = 1'b1;
                    r_d.pend[i]  = 1'b0;
                end
            end else if (wr_hit[i]) begin
                r_d.pend[i]      = 1'b1;
                r_d.pend_addr[i] = host_wdata[UTX_AW-1:0];
            end
        end
    end

    always_comb begin
        host_rdata = 8'h00;
        if (host_addr == PTR_OFS) begin
            host_rdata[UTX_AW-1:0] = r_q.ptr;
        end else if (host_addr == ADR_OFS) begin
            for (int i = 0; i < NCH; i++) begin
                if (r_q.ptr == UTX_AW'(i)) host_rdata[UTX_AW-1:0] = r_q.addr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tbl_addr  = r_q.addr;
    assign tbl_valid = r_q.valid;

    // Table must not move while a cell is in flight (R9)
    assert_tbl_frozen_in_cell_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cell_active |=> $stable(r_q.addr));
    // Valid flags never drop once set (R3)
    assert_valid_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.valid & $past(r_q.valid)) == $past(r_q.valid)));
endmodule

// File: rtl/utx_poll_sel.sv
module utx_poll_sel
    import utx_pkg::*;
#(
    parameter int NCH        = 3,
    parameter int CELL_BYTES = 53
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     txenb_n,
    input  utx_addr_t                txaddr,
    input  logic                     txsoc,
    input  logic [NCH-1:0]           ch_space,
    input  logic [NCH-1:0][UTX_AW-1:0] tbl_addr,
    input  logic [NCH-1:0]           tbl_valid,
    output logic                     clav,
    output logic                     clav_oe,
    output logic [NCH-1:0]           ch_soc,
    output logic [NCH-1:0]           ch_wr,
    output logic                     cell_active
);
    localparam int CW = $clog2(CELL_BYTES + 1);

    typedef struct packed {
        logic [NCH-1:0] sel;
        logic           clav;
        logic           oe;
        logic           active;
        logic [CW-1:0]  cnt;
    } bus_t;

    bus_t s_d, s_q;
    logic [NCH-1:0] pick;
    logic           any_hit;
    logic           beat;

    always_comb begin
        pick    = '0;
        any_hit = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (!any_hit && tbl_valid[i] && (tbl_addr[i] == txaddr)
                && (txaddr != UTX_NULL_ADDR)) begin
                pick[i] = 1'b1;
                any_hit = 1'b1;
            end
        end
    end

    assign beat = !txenb_n && (|s_q.sel);

    always_comb begin
        s_d      = s_q;
        s_d.clav = 1'b0;
        s_d.oe   = 1'b0;
        if (txenb_n) begin
            if (any_hit) begin
                s_d.oe   = 1'b1;
                s_d.clav = |(pick & ch_space);
                s_d.sel  = pick;
            end else if (txaddr != UTX_NULL_ADDR) begin
                s_d.sel  = '0;
            end
        end
        if (beat && txsoc) begin
            s_d.cnt    = CW'(1);
            s_d.active = 1'b1;
        end else if (beat && s_q.active) begin
            if (s_q.cnt == CW'(CELL_BYTES - 1)) begin
                s_d.cnt    = '0;
                s_d.active = 1'b0;
            end else begin
                s_d.cnt    = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clav        = s_q.clav;
    assign clav_oe     = s_q.oe;
    assign ch_wr       = {NCH{!txenb_n}} & s_q.sel;
    assign ch_soc      = ch_wr & {NCH{txsoc}};
    assign cell_active = s_q.active;

    assert_null_never_answers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (txenb_n && txaddr == UTX_NULL_ADDR) |=> !clav_oe);
    assert_no_answer_under_enb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !txenb_n |=> !clav_oe);
    assert_clav_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clav_oe |-> !clav);
    assert_sel_held_under_enb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !txenb_n |=> $stable(s_q.sel));
    assert_wr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr));
endmodule

// File: rtl/utx_mphy_addr_match.sv
module utx_mphy_addr_match
    import utx_pkg::*;
#(
    parameter int NCH        = 3,
    parameter int CELL_BYTES = 53,
    parameter int HAW        = 12,
    parameter logic [HAW-1:0] PTR_OFS = 12'h597,
    parameter logic [HAW-1:0] ADR_OFS = 12'h593
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [HAW-1:0]       host_addr,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    input  logic                 txenb_n,
    input  logic [UTX_AW-1:0]    txaddr,
    input  logic                 txsoc,
    input  logic [NCH-1:0]       ch_space,
    output logic                 clav,
    output logic                 clav_oe,
    output logic [NCH-1:0]       ch_soc,
    output logic [NCH-1:0]       ch_wr
);
    logic [NCH-1:0][UTX_AW-1:0] tbl_addr;
    logic [NCH-1:0]             tbl_valid;
    logic                       cell_active;

    utx_addr_regs #(
        .NCH(NCH), .HAW(HAW), .PTR_OFS(PTR_OFS), .ADR_OFS(ADR_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cell_active(cell_active),
        .tbl_addr(tbl_addr), .tbl_valid(tbl_valid)
    );

    utx_poll_sel #(
        .NCH(NCH), .CELL_BYTES(CELL_BYTES)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .txenb_n(txenb_n), .txaddr(txaddr), .txsoc(txsoc),
        .ch_space(ch_space),
        .tbl_addr(tbl_addr), .tbl_valid(tbl_valid),
        .clav(clav), .clav_oe(clav_oe),
        .ch_soc(ch_soc), .ch_wr(ch_wr),
        .cell_active(cell_active)
    );
endmodule

// File: tb/tb_utx_mphy_addr_match.sv
module tb_utx_mphy_addr_match;
    localparam int NCH = 3;
    localparam logic [11:0] PTR = 12'h597;
    localparam logic [11:0] ADR = 12'h593;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0;
    logic [11:0] host_addr = 12'h000;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic txenb_n = 1'b1;
    logic [4:0] txaddr = 5'h1F;
    logic txsoc = 1'b0;
    logic [NCH-1:0] ch_space = '0;
    logic clav, clav_oe;
    logic [NCH-1:0] ch_soc, ch_wr;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    utx_mphy_addr_match dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .txenb_n(txenb_n), .txaddr(txaddr), .txsoc(txsoc), .ch_space(ch_space),
        .clav(clav), .clav_oe(clav_oe), .ch_soc(ch_soc), .ch_wr(ch_wr)
    );

    // ---------------- behavioural reference ----------------
    int m_addr [NCH];
    bit m_valid [NCH];
    bit m_pend [NCH];
    int m_paddr [NCH];
    int m_ptr, m_sel, m_cnt;
    bit m_active, m_clav, m_oe;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_addr[i] = 0; m_valid[i] = 0; m_pend[i] = 0; m_paddr[i] = 0;
            end
            m_ptr = 0; m_sel = -1; m_cnt = 0; m_active = 0; m_clav = 0; m_oe = 0;
        end else begin
            bit o_active;
            int o_sel, o_ptr, found;
            o_active = m_active; o_sel = m_sel; o_ptr = m_ptr;
            m_oe = 0; m_clav = 0;
            if (txenb_n) begin
                found = -1;
                for (int i = 0; i < NCH; i++)
                    if (found < 0 && m_valid[i] && m_addr[i] == int'(txaddr) && txaddr != 5'h1F)
                        found = i;
                if (found >= 0) begin
                    m_oe = 1; m_clav = ch_space[found]; m_sel = found;
                end else if (txaddr != 5'h1F) begin
                    m_sel = -1;
                end
            end
            if (!txenb_n && o_sel >= 0) begin
                if (txsoc) begin
                    m_cnt = 1; m_active = 1;
                end else if (o_active) begin
                    m_cnt++;
                    if (m_cnt == 53) begin m_cnt = 0; m_active = 0; end
                end
            end
            for (int i = 0; i < NCH; i++) begin
                bit hit;
                hit = host_wr && host_addr == ADR && o_ptr == i;
                if (!o_active) begin
                    if (hit) begin
                        m_addr[i] = int'(host_wdata[4:0]); m_valid[i] = 1; m_pend[i] = 0;
                    end else if (m_pend[i]) begin
                        m_addr[i] = m_paddr[i]; m_valid[i] = 1; m_pend[i] = 0;
                    end
                end else if (hit) begin
                    m_pend[i] = 1; m_paddr[i] = int'(host_wdata[4:0]);
                end
            end
            if (host_wr && host_addr == PTR) m_ptr = int'(host_wdata[4:0]);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_wr, e_rd;
            e_wr = (!txenb_n && m_sel >= 0) ? (1 << m_sel) : 0;
            if (host_addr == PTR)      e_rd = m_ptr;
            else if (host_addr == ADR) e_rd = (m_ptr < NCH) ? m_addr[m_ptr] : 0;
            else                       e_rd = 0;
            check("R4/R5", "clav_oe", int'(clav_oe), int'(m_oe));
            check("R4", "clav", int'(clav), int'(m_clav));
            check("R8", "ch_wr", int'(ch_wr), e_wr);
            check("R8", "ch_soc", int'(ch_soc), txsoc ? e_wr : 0);
            check("R2", "host_rdata", int'(host_rdata), e_rd);
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic hwrite(input logic [11:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        step();
        host_wr = 1'b0;
    endtask

    task automatic poll(input logic [4:0] a);
        txenb_n = 1'b1; txaddr = a;
        step();
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual hung expected finished");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step();
        // R3: reset state
        host_addr = PTR; #1;
        check("R3", "pointer after reset", int'(host_rdata), 0);
        host_addr = ADR; #1;
        check("R3", "address after reset", int'(host_rdata), 0);
        check("R3", "clav_oe after reset", int'(clav_oe), 0);
        poll(5'h00);
        check("R3", "unprogrammed ch does not answer", int'(clav_oe), 0);

        // R1: pointer register, upper bits masked
        hwrite(PTR, 8'hE2);
        host_addr = PTR; #1;
        check("R1", "pointer readback", int'(host_rdata), 8'h02);
        host_addr = 12'h100; #1;
        check("R1", "other offset reads 0", int'(host_rdata), 0);

        // program channels
        hwrite(PTR, 8'h00); hwrite(ADR, 8'hE5);
        hwrite(PTR, 8'h01); hwrite(ADR, 8'h09);
        hwrite(PTR, 8'h02); hwrite(ADR, 8'h1F);
        hwrite(PTR, 8'h00);
        host_addr = ADR; #1;
        check("R2", "ch0 address readback", int'(host_rdata), 8'h05);
        hwrite(PTR, 8'h03); hwrite(ADR, 8'h04);
        host_addr = ADR; #1;
        check("R2", "out-of-range pointer reads 0", int'(host_rdata), 0);

        // R4 / R5 / R6: polling
        ch_space = 3'b101;
        poll(5'h05);
        check("R4", "poll ch0 oe", int'(clav_oe), 1);
        check("R4", "poll ch0 clav", int'(clav), 1);
        poll(5'h09);
        check("R4", "poll ch1 oe", int'(clav_oe), 1);
        check("R4", "poll ch1 clav", int'(clav), 0);
        poll(5'h1F);
        check("R6", "null addr no answer", int'(clav_oe), 0);
        poll(5'h07);
        check("R5", "unowned addr no answer", int'(clav_oe), 0);
        txenb_n = 1'b0; txaddr = 5'h05; step();
        check("R5", "no answer while enb low", int'(clav_oe), 0);
        txenb_n = 1'b1;

        // R7: selection rules
        poll(5'h05);
        txenb_n = 1'b0; #1;
        check("R7", "ch0 selected", int'(ch_wr), 3'b001);
        poll(5'h1F);
        txenb_n = 1'b0; #1;
        check("R7", "null keeps selection", int'(ch_wr), 3'b001);
        poll(5'h07);
        txenb_n = 1'b0; #1;
        check("R7", "foreign addr clears selection", int'(ch_wr), 3'b000);

        // R9: full cell on ch1 with a write in the middle
        hwrite(PTR, 8'h01);
        poll(5'h09);
        host_addr = ADR;
        for (int b = 0; b < 53; b++) begin
            txenb_n = 1'b0;
            txsoc = (b == 0);
            host_wr = (b == 20);
            host_wdata = 8'h0C;
            if (b == 0) begin
                #1 check("R8", "soc routed to ch1", int'(ch_soc), 3'b010);
            end
            step();
            if (b == 30) check("R9", "write deferred during cell", int'(host_rdata), 8'h09);
        end
        host_wr = 1'b0; txsoc = 1'b0; txenb_n = 1'b1; txaddr = 5'h1F;
        step();
        step();
        check("R9", "deferred write applied after cell", int'(host_rdata), 8'h0C);

        // R10: shared address, lowest index wins
        hwrite(PTR, 8'h00); hwrite(ADR, 8'h0C);
        ch_space = 3'b010;
        poll(5'h0C);
        check("R10", "shared addr answered by ch0", int'(clav), 0);
        check("R10", "shared addr oe", int'(clav_oe), 1);
        txenb_n = 1'b0; #1;
        check("R10", "shared addr selects ch0", int'(ch_wr), 3'b001);
        step();
        txenb_n = 1'b1;
        step(); step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule